// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Bank

This block is the programming front end of a frequency synthesizer. A host shifts 24-bit words in over a three-wire link (serial clock, serial data, load strobe). The most significant bit goes first. When the load strobe rises, the two least significant bits of the word pick one of three configuration latches: reference divider, feedback divider, or function settings. The chosen latch takes the whole word. The stored fields are decoded onto output ports that feed the counters, the charge pump and the power control of the synthesizer.

The block also combines the chip-enable pin with a software power-down bit. It forces the charge pump to three-state whenever it is powered down. It drives a status output through a 3-bit multiplexer that selects lock detect, divider outputs, fixed levels or the serial data tap. A one-cycle gain-clear pulse from the fast-lock timer clears only the charge-pump gain bit of the feedback latch.

The three serial pins are asynchronous to the system clock. They pass through a synchronizer of `SYNC_STAGES` flops, and edges are found after that. The data line is delayed by the same number of flops, so it stays aligned with the serial clock.

Top module: `serial_cfg_bank`

## Requirements
- R1: Serial data is sampled on each rising edge of the serial clock and enters a 24-bit shift register MSB first, so the bit sent first lands in word bit 23 at the load.
- R2: A load-strobe rising edge with control code 00 in word bits [1:0] stores the word in the reference latch; `r_div` shows word bits [15:2].
- R3: Control code 01 stores the feedback latch: `a_cnt` = bits [7:2], `b_cnt` = bits [20:8], `cp_gain` = bit 21.
- R4: Control code 10 stores the function latch: `cnt_rst` bit 2, software power-down bit 3, mux select [6:4], `pd_pol` bit 7, three-state bit 8, `fl_en` bit 9, `fl_mode` bit 10, `timer_code` [14:11], `cur_set1` [17:15], `cur_set2` [20:18], `presc_sel` [23:22].
- R5: A load with control code 11 changes none of the three latches.
- R6: After reset all latch fields are zero and `cfg_done` is 0.
- R7: A gain-clear pulse clears `cp_gain` and leaves every other field unchanged.
- R8: `power_down` is 1 whenever `chip_en` is 0, in the same cycle and whatever the software bit holds. With `chip_en` at 1 it follows the software power-down bit (function bit 3).
- R9: `cp_hiz` is 1 when function bit 8 is 1 or `power_down` is 1, and 0 otherwise.
- R10: The mux select drives `mux_out`/`mux_oe` as follows. 000: `mux_oe`=0. 001: lock detect. 010: feedback divider output. 011: 1. 100: reference divider output. 101: 0. 110: shift-register bit 23. 111: 0. `mux_oe` is 1 for every code except 000.
- R11: While powered down, words still shift in and load into the latches.
- R12: `cfg_done` rises only after each of the three latches has been written at least once since reset, and then stays 1.
- R13: Shifting without a load-strobe edge changes no latch. A later strobe alone loads whatever the shift register holds at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; rising edge transfers the word |
| chip_en | input | 1 | Chip enable; low forces power-down |
| gain_clr | input | 1 | One-cycle pulse clearing the gain bit |
| lock_det | input | 1 | Lock detect status for the mux |
| n_div_out | input | 1 | Feedback divider output for the mux |
| r_div_out | input | 1 | Reference divider output for the mux |
| r_div | output | 14 | Reference divide value |
| a_cnt | output | 6 | Swallow counter value |
| b_cnt | output | 13 | Main counter value |
| cp_gain | output | 1 | Charge-pump gain bit |
| presc_sel | output | 2 | Prescaler code |
| cur_set1 | output | 3 | Charge-pump current code, steady state |
| cur_set2 | output | 3 | Charge-pump current code, fast lock |
| timer_code | output | 4 | Fast-lock timeout code |
| fl_en | output | 1 | Fast-lock enable |
| fl_mode | output | 1 | Fast-lock mode select |
| pd_pol | output | 1 | Phase detector polarity |
| cnt_rst | output | 1 | Counter reset request |
| power_down | output | 1 | Combined power-down |
| cp_hiz | output | 1 | Charge pump three-state |
| mux_out | output | 1 | Status mux value |
| mux_oe | output | 1 | Status mux drive enable |
| cfg_done | output | 1 | All three latches written since reset |

## Verification
The hardest state to reach from the ports is a shift register that holds one word while the latches hold another. That state is needed for the strobe-only load of R13 and for the serial-data tap of R10. The bench reaches it by clocking a full word in with the strobe held low and checking that no field moves. It then raises the strobe on its own and checks the load. The serial tap is checked after function words whose bit 23 differs, so the mux output must follow the shift register rather than a constant.

// File: rtl/cfg_bank_pkg.sv
// Package: shared widths, control codes and mux select encoding for the
// serial configuration bank. Assumes a fixed 24-bit word with control bits
// in the two least significant positions.
package cfg_bank_pkg;
    localparam int unsigned WORD_W  = 24;
    localparam int unsigned CTL_W   = 2;
    localparam int unsigned N_LATCH = 3;

    localparam logic [CTL_W-1:0] CTL_REF  = 2'b00;
    localparam logic [CTL_W-1:0] CTL_FB   = 2'b01;
    localparam logic [CTL_W-1:0] CTL_FUNC = 2'b10;

    // Bit position of the gain bit in the feedback word
    localparam int unsigned GAIN_BIT = 21;

    typedef enum logic [2:0] {
        MX_OFF  = 3'd0,
        MX_LOCK = 3'd1,
        MX_NDIV = 3'd2,
        MX_HIGH = 3'd3,
        MX_RDIV = 3'd4,
        MX_RSVD = 3'd5,
        MX_SDO  = 3'd6,
        MX_LOW  = 3'd7
    } mux_sel_e;
endpackage

// File: rtl/cfg_sync.sv
// Module: multi-bit synchronizer with rising-edge detect per bit.
// Assumes each bit is a slow asynchronous level held for several clocks;
// all bits see the same number of stages so they stay mutually aligned.
module cfg_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out,
    output logic [W-1:0] rise
);
    logic [W-1:0] stage [STAGES];
    logic [W-1:0] prev;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the asynchronous pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[s] <= '0;
                    else        stage[s] <= d_in;
                end
            end else begin : g_next
                // Later flops settle the value further
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[s] <= '0;
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    // Holds last synchronized value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= stage[STAGES-1];
    end

    assign q_out = stage[STAGES-1];
    assign rise  = stage[STAGES-1] & ~prev;
endmodule

// File: rtl/cfg_shift.sv
// Module: serial input shift register, MSB first.
// Assumes shift_en is a single-cycle pulse per serial clock edge.
module cfg_shift #(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);
    // Shifts one bit in at the bottom per serial edge
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
    end
endmodule

// File: rtl/cfg_latches.sv
// Module: three configuration latches addressed by the word's control bits,
// plus per-latch written flags. Assumes load is a single-cycle pulse; a load
// to the feedback latch takes priority over a simultaneous gain clear.
module cfg_latches
    import cfg_bank_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [W-1:0]         word,
    input  logic                 gain_clr,
    output logic [N_LATCH*W-1:0] lat_flat,
    output logic                 all_seen
);
    logic [N_LATCH-1:0] seen_vec;

    genvar g;
    generate
        for (g = 0; g < N_LATCH; g++) begin : g_lat
            localparam int unsigned SEL = g;
            logic [W-1:0] q;
            logic         seen;

            if (g == int'(CTL_FB)) begin : g_fb
                // Feedback latch: load, or clear gain bit on request
                always_ff @(posedge clk) begin
                    if (!rst_n)                                q <= '0;
                    else if (load && word[1:0] == SEL[1:0])    q <= word;
                    else if (gain_clr)                         q[GAIN_BIT] <= 1'b0;
                end
            end else begin : g_plain
                // Plain latch: load on matching control code
                always_ff @(posedge clk) begin
                    if (!rst_n)                                q <= '0;
                    else if (load && word[1:0] == SEL[1:0])    q <= word;
                end
            end

            // Remembers that this latch has been written since reset
            always_ff @(posedge clk) begin
                if (!rst_n)                                seen <= 1'b0;
                else if (load && word[1:0] == SEL[1:0])    seen <= 1'b1;
            end

            assign lat_flat[g*W +: W] = q;
            assign seen_vec[g]        = seen;
        end
    endgenerate

    assign all_seen = &seen_vec;
endmodule

// File: rtl/cfg_outmux.sv
// Module: status output multiplexer. Purely combinational; assumes the
// select comes from a registered latch field.
module cfg_outmux
    import cfg_bank_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       lock_det,
    input  logic       n_div_out,
    input  logic       r_div_out,
    input  logic       sdo,
    output logic       out_val,
    output logic       out_oe
);
    mux_sel_e sel_e;
    assign sel_e = mux_sel_e'(sel);

    // Picks the observed source and the drive enable
    always_comb begin
        out_oe  = 1'b1;
        out_val = 1'b0;
        case (sel_e)
            MX_OFF:  out_oe  = 1'b0;
            MX_LOCK: out_val = lock_det;
            MX_NDIV: out_val = n_div_out;
            MX_HIGH: out_val = 1'b1;
            MX_RDIV: out_val = r_div_out;
            MX_RSVD: out_val = 1'b0;
            MX_SDO:  out_val = sdo;
            MX_LOW:  out_val = 1'b0;
            default: out_val = 1'b0;
        endcase
    end
endmodule

// File: rtl/serial_cfg_bank.sv
// Module: top of the three-wire configuration bank. Synchronizes the serial
// pins, shifts words in, routes them to latches on load-strobe edges and
// decodes fields. Assumes serial pins change slowly relative to clk
// (each level held for more than SYNC_STAGES+1 clocks).
module serial_cfg_bank
    import cfg_bank_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_data,
    input  logic        ser_le,
    input  logic        chip_en,
    input  logic        gain_clr,
    input  logic        lock_det,
    input  logic        n_div_out,
    input  logic        r_div_out,
    output logic [13:0] r_div,
    output logic [5:0]  a_cnt,
    output logic [12:0] b_cnt,
    output logic        cp_gain,
    output logic [1:0]  presc_sel,
    output logic [2:0]  cur_set1,
    output logic [2:0]  cur_set2,
    output logic [3:0]  timer_code,
    output logic        fl_en,
    output logic        fl_mode,
    output logic        pd_pol,
    output logic        cnt_rst,
    output logic        power_down,
    output logic        cp_hiz,
    output logic        mux_out,
    output logic        mux_oe,
    output logic        cfg_done
);
    localparam int unsigned PIN_W = 3;

    logic [PIN_W-1:0]          pin_q;
    logic [PIN_W-1:0]          pin_rise;
    logic                      clk_rise;
    logic                      le_rise;
    logic                      data_q;
    logic [WORD_W-1:0]         shift_word;
    logic [N_LATCH*WORD_W-1:0] lat_flat;
    logic [WORD_W-1:0]         ref_q;
    logic [WORD_W-1:0]         fb_q;
    logic [WORD_W-1:0]         fn_q;
    logic                      sw_pd;
    logic                      unused_bits;

    cfg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ser_le, ser_data, ser_clk}),
        .q_out (pin_q),
        .rise  (pin_rise)
    );

    assign clk_rise = pin_rise[0];
    assign data_q   = pin_q[1];
    assign le_rise  = pin_rise[2];

    cfg_shift #(.WORD_W(WORD_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (clk_rise),
        .bit_in   (data_q),
        .word     (shift_word)
    );

    cfg_latches #(.W(WORD_W)) i_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (le_rise),
        .word     (shift_word),
        .gain_clr (gain_clr),
        .lat_flat (lat_flat),
        .all_seen (cfg_done)
    );

    assign ref_q = lat_flat[int'(CTL_REF)*WORD_W  +: WORD_W];
    assign fb_q  = lat_flat[int'(CTL_FB)*WORD_W   +: WORD_W];
    assign fn_q  = lat_flat[int'(CTL_FUNC)*WORD_W +: WORD_W];

    // Field decode
    assign r_div      = ref_q[15:2];
    assign a_cnt      = fb_q[7:2];
    assign b_cnt      = fb_q[20:8];
    assign cp_gain    = fb_q[GAIN_BIT];
    assign cnt_rst    = fn_q[2];
    assign sw_pd      = fn_q[3];
    assign pd_pol     = fn_q[7];
    assign fl_en      = fn_q[9];
    assign fl_mode    = fn_q[10];
    assign timer_code = fn_q[14:11];
    assign cur_set1   = fn_q[17:15];
    assign cur_set2   = fn_q[20:18];
    assign presc_sel  = fn_q[23:22];

    assign power_down = ~chip_en | sw_pd;
    assign cp_hiz     = fn_q[8] | power_down;

    cfg_outmux i_mux (
        .sel       (fn_q[6:4]),
        .lock_det  (lock_det),
        .n_div_out (n_div_out),
        .r_div_out (r_div_out),
        .sdo       (shift_word[WORD_W-1]),
        .out_val   (mux_out),
        .out_oe    (mux_oe)
    );

    // Reserved and control bits are stored but not decoded
    assign unused_bits = ^{ref_q[23:16], ref_q[1:0], fb_q[23:22], fb_q[1:0],
                           fn_q[21], fn_q[1:0], pin_rise[1], pin_q[0], pin_q[2]};
endmodule

// File: rtl/serial_cfg_bank_chk.sv
// Checker: temporal properties of the configuration bank, bound to the top.
module serial_cfg_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        le_rise,
    input logic [1:0]  ctl,
    input logic        chip_en,
    input logic        gain_clr,
    input logic [13:0] r_div,
    input logic [5:0]  a_cnt,
    input logic [12:0] b_cnt,
    input logic        cp_gain,
    input logic [1:0]  presc_sel,
    input logic        power_down,
    input logic        cp_hiz,
    input logic        mux_oe,
    input logic [3:0]  timer_code,
    input logic        cfg_done
);
    a_r5_code3_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && ctl == 2'b11) |=> ($stable(r_div) && $stable(a_cnt) &&
                                      $stable(b_cnt) && $stable(presc_sel) &&
                                      $stable(timer_code)));

    a_r13_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> ($stable(r_div) && $stable(b_cnt) && $stable(presc_sel)));

    a_r7_gain_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_clr && !le_rise) |=> !cp_gain);

    a_r8_ce_forces_pd: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> power_down);

    a_r9_pd_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |-> cp_hiz);

    a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);

    a_r12_done_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(le_rise));
endmodule

bind serial_cfg_bank serial_cfg_bank_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .le_rise    (le_rise),
    .ctl        (shift_word[1:0]),
    .chip_en    (chip_en),
    .gain_clr   (gain_clr),
    .r_div      (r_div),
    .a_cnt      (a_cnt),
    .b_cnt      (b_cnt),
    .cp_gain    (cp_gain),
    .presc_sel  (presc_sel),
    .power_down (power_down),
    .cp_hiz     (cp_hiz),
    .mux_oe     (mux_oe),
    .timer_code (timer_code),
    .cfg_done   (cfg_done)
);

// File: tb/test_serial_cfg_bank.sv
module test_serial_cfg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic        chip_en = 1'b1, gain_clr = 1'b0;
    logic        lock_det = 1'b0, n_div_out = 1'b0, r_div_out = 1'b0;
    logic [13:0] r_div;
    logic [5:0]  a_cnt;
    logic [12:0] b_cnt;
    logic        cp_gain, fl_en, fl_mode, pd_pol, cnt_rst;
    logic        power_down, cp_hiz, mux_out, mux_oe, cfg_done;
    logic [1:0]  presc_sel;
    logic [2:0]  cur_set1, cur_set2;
    logic [3:0]  timer_code;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    serial_cfg_bank i_serial_cfg_bank (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .chip_en(chip_en), .gain_clr(gain_clr),
        .lock_det(lock_det), .n_div_out(n_div_out), .r_div_out(r_div_out),
        .r_div(r_div), .a_cnt(a_cnt), .b_cnt(b_cnt), .cp_gain(cp_gain),
        .presc_sel(presc_sel), .cur_set1(cur_set1), .cur_set2(cur_set2),
        .timer_code(timer_code), .fl_en(fl_en), .fl_mode(fl_mode),
        .pd_pol(pd_pol), .cnt_rst(cnt_rst), .power_down(power_down),
        .cp_hiz(cp_hiz), .mux_out(mux_out), .mux_oe(mux_oe),
        .cfg_done(cfg_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic strobe();
        ser_le = 1'b1; wait_clk(8);
        ser_le = 1'b0; wait_clk(8);
        @(negedge clk);
    endtask

    task automatic shift_word(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) begin
            ser_data = w[i]; wait_clk(6);
            ser_clk  = 1'b1; wait_clk(6);
            ser_clk  = 1'b0; wait_clk(2);
        end
    endtask

    task automatic load_word(input logic [23:0] w);
        shift_word(w);
        strobe();
    endtask

    function automatic logic [23:0] ref_w(input logic [7:0] junk, input logic [13:0] r);
        return {junk, r, 2'b00};
    endfunction

    function automatic logic [23:0] fb_w(input logic g, input logic [12:0] b, input logic [5:0] a);
        return {2'b00, g, b, a, 2'b01};
    endfunction

    function automatic logic [23:0] fn_w(input logic [1:0] pr, input logic [2:0] c2,
            input logic [2:0] c1, input logic [3:0] tc, input logic flm, input logic fle,
            input logic tri3, input logic pol, input logic [2:0] mx, input logic pd1,
            input logic crst);
        return {pr, 1'b0, c2, c1, tc, flm, fle, tri3, pol, mx, pd1, crst, 2'b10};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R6 r_div", 32'(r_div), 0);
        check("R6 b_cnt", 32'(b_cnt), 0);
        check("R6 presc", 32'(presc_sel), 0);
        check("R6 cfg_done", 32'(cfg_done), 0);
        check("R6 mux_oe", 32'(mux_oe), 0);
    endtask

    task automatic t_ref();
        load_word(ref_w(8'hA5, 14'h2A5B));
        check("R2 r_div", 32'(r_div), 32'h2A5B);
        check("R1 R12 cfg_done after one", 32'(cfg_done), 0);
        load_word(ref_w(8'h00, 14'h3FFF));
        check("R2 r_div max", 32'(r_div), 32'h3FFF);
    endtask

    task automatic t_fb();
        load_word(fb_w(1'b1, 13'd5000, 6'd37));
        check("R3 a_cnt", 32'(a_cnt), 37);
        check("R3 b_cnt", 32'(b_cnt), 5000);
        check("R3 cp_gain", 32'(cp_gain), 1);
        check("R12 cfg_done after two", 32'(cfg_done), 0);
    endtask

    task automatic t_fn();
        load_word(fn_w(2'b01, 3'd6, 3'd3, 4'hB, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1));
        check("R4 presc", 32'(presc_sel), 1);
        check("R4 cur2", 32'(cur_set2), 6);
        check("R4 cur1", 32'(cur_set1), 3);
        check("R4 timer", 32'(timer_code), 11);
        check("R4 fl_mode", 32'(fl_mode), 1);
        check("R4 fl_en", 32'(fl_en), 0);
        check("R4 pd_pol", 32'(pd_pol), 1);
        check("R4 cnt_rst", 32'(cnt_rst), 1);
        check("R4 power_down", 32'(power_down), 0);
        check("R12 cfg_done", 32'(cfg_done), 1);
    endtask

    task automatic t_code3();
        load_word(24'hFFFFFF);
        check("R5 r_div", 32'(r_div), 32'h3FFF);
        check("R5 a_cnt", 32'(a_cnt), 37);
        check("R5 b_cnt", 32'(b_cnt), 5000);
        check("R5 presc", 32'(presc_sel), 1);
        check("R5 timer", 32'(timer_code), 11);
    endtask

    task automatic t_no_strobe();
        shift_word(ref_w(8'h00, 14'h0123));
        wait_clk(8); @(negedge clk);
        check("R13 held without strobe", 32'(r_div), 32'h3FFF);
        strobe();
        check("R13 strobe-only load", 32'(r_div), 32'h0123);
        check("R12 sticky", 32'(cfg_done), 1);
    endtask

    task automatic t_gain_clr();
        @(negedge clk); gain_clr = 1'b1;
        @(negedge clk); gain_clr = 1'b0;
        @(negedge clk);
        check("R7 cp_gain cleared", 32'(cp_gain), 0);
        check("R7 a_cnt kept", 32'(a_cnt), 37);
        check("R7 b_cnt kept", 32'(b_cnt), 5000);
        check("R7 r_div kept", 32'(r_div), 32'h0123);
    endtask

    task automatic t_power();
        chip_en = 1'b0; #1;
        check("R8 ce low", 32'(power_down), 1);
        check("R9 hiz on pd", 32'(cp_hiz), 1);
        load_word(ref_w(8'h00, 14'h0777));
        check("R11 load in pd", 32'(r_div), 32'h0777);
        chip_en = 1'b1; #1;
        check("R8 ce high", 32'(power_down), 0);
        check("R9 hiz off", 32'(cp_hiz), 0);
        load_word(fn_w(2'b00, 3'd0, 3'd0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0));
        check("R8 software pd", 32'(power_down), 1);
        check("R9 hiz sw pd", 32'(cp_hiz), 1);
        load_word(fn_w(2'b00, 3'd0, 3'd0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0));
        check("R8 sw pd off", 32'(power_down), 0);
        check("R9 three-state bit", 32'(cp_hiz), 1);
    endtask

    function automatic logic [1:0] mux_exp(input logic [2:0] s, input logic ld,
            input logic nd, input logic rd, input logic sd);
        case (s)
            3'd0: return 2'b00;
            3'd1: return {1'b1, ld};
            3'd2: return {1'b1, nd};
            3'd3: return 2'b11;
            3'd4: return {1'b1, rd};
            3'd6: return {1'b1, sd};
            default: return 2'b10;
        endcase
    endfunction

    task automatic t_mux();
        for (int s = 0; s < 8; s++) begin
            for (int pr = 1; pr <= 2; pr++) begin
                load_word(fn_w(2'(pr), 3'd0, 3'd0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0,
                               3'(s), 1'b0, 1'b0));
                lock_det = 1'b1; n_div_out = 1'b0; r_div_out = 1'b1; #1;
                check($sformatf("R10 sel %0d pat A", s), 32'({mux_oe, mux_out}),
                      32'(mux_exp(3'(s), 1'b1, 1'b0, 1'b1, pr[1])));
                lock_det = 1'b0; n_div_out = 1'b1; r_div_out = 1'b0; #1;
                check($sformatf("R10 sel %0d pat B", s), 32'({mux_oe, mux_out}),
                      32'(mux_exp(3'(s), 1'b0, 1'b1, 1'b0, pr[1])));
            end
        end
    endtask

    initial begin
        wait_clk(150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_ref();
        t_fb();
        t_fn();
        t_code3();
        t_no_strobe();
        t_gain_clr();
        t_power();
        t_mux();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule